// File: doc/BRIEF.md
# Configuration Space Register File

This block holds the 256-byte configuration space of one bus function and answers configuration reads and writes of 1, 2 or 4 bytes. A request carries a 24-bit configuration address: bits 23:16 give the bus number, bits 15:8 give the device-function, and bits 7:0 give the byte offset. The block answers only when the bus and device-function match its own parameters. For any other target it behaves as an empty slot. A read of an empty slot returns all ones, sized to the access.

Writes pass through a byte-by-byte protection table. The table depends on the header type: an ordinary header uses one table and a bridge header uses another. Full-dword writes to an implemented base address register are forced to that region's size alignment, and the region's type bits are kept. The block drives the command register, all seven base address values (six regions plus the expansion ROM, index 6), the bridge secondary bus number and a one-cycle remap pulse to a downstream address decoder.

Top module: `cfgspace_rf`

## Requirements
- R1: A request is served only when address bits 23:16 equal OWN_BUS and bits 15:8 equal OWN_DEVFN. Writes to any other bus or device-function leave all contents unchanged.
- R2: A read of a non-matching target returns 32'h000000FF for size code 0, 32'h0000FFFF for size code 1, and 32'hFFFFFFFF for size codes 2 and 3.
- R3: req_ready is always high. rsp_valid is high exactly in the cycle after each accepted read and is never set by a write.
- R4: Size codes 0, 1 and 2/3 mean 1, 2 and 4 bytes, packed little-endian from the offset. A 4-byte read above offset 0xFC falls back to 2 bytes, and a 2-byte read above 0xFE falls back to 1 byte. Unread upper bytes return zero.
- R5: Reset loads the following and clears every other byte:
  - vendor ID at 0x00-0x01 and device ID at 0x02-0x03;
  - revision at 0x08 and class code at 0x09-0x0B;
  - header type at 0x0E and interrupt pin at 0x3D;
  - the I/O type bit (bit 0 = 1) in each implemented I/O base register.
- R6: With a header type whose low 7 bits are zero, ordinary writes cannot change these bytes: 0x00-0x03, 0x06-0x0B, 0x0E, 0x10-0x27, 0x2C-0x2F, 0x30-0x33 and 0x3D. Every other byte is writable.
- R7: With any other header type (bridge), the same set is protected, except that 0x10-0x27 is writable byte by byte and the protected ROM bytes are 0x38-0x3B instead of 0x30-0x33.
- R8: Consider a size-2/3 write at a dword-aligned base register offset (0x10 + 4k, k = 0..5) of an implemented region of size 2^L. It stores the data ANDed with ~(2^L - 1), with bit 0 set for an I/O region. Writes to unimplemented regions follow the byte table.
- R9: A size-2/3 write at the ROM offset stores the data ANDed with ~(2^L - 1) while keeping bit 0 as the ROM enable. The ROM offset is 0x30 for an ordinary header and 0x38 for a bridge.
- R10: Multi-byte writes apply byte by byte and stop after offset 0xFF, with no wrap to offset 0.
- R11: Bits 15:11 of the command register (byte 0x05 bits 7:3) are reserved and always stored as zero.
- R12: remap pulses for one cycle after an accepted write that either touches offsets 0x04-0x05 or takes the base register path of R8/R9. It stays low otherwise.
- R13: On a bridge, sec_bus shows byte 0x19. On an ordinary header, sec_bus is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = byte, 1 = word, 2/3 = dword |
| req_addr | input | 24 | Bus, device-function and offset |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| cmd_reg | output | 16 | Command register (0x04-0x05) |
| bar_flat | output | 224 | Seven 32-bit base values, index 6 = ROM |
| sec_bus | output | 8 | Bridge secondary bus number |
| remap | output | 1 | Mapping refresh pulse |

## Verification
Two instances share one request bus: an ordinary header and a bridge header, at different device-functions. Every read therefore exercises one hit and one empty-slot answer, which checks the routing and the all-ones sizing. A byte write to every offset of both instances, followed by reads at every offset in each width, separates the two protection tables and shows where the read width falls back at the top of the space. Dword writes of all ones and of mixed patterns to implemented, unimplemented and ROM registers show the alignment masking, the type bit and the ROM enable bit. A long pseudo-random mix of sizes, offsets and targets then tests the interactions against an arithmetic model of the byte rules.

// File: rtl/cfgspace_rf.sv
module cfgspace_rf #(
  parameter logic [7:0]  OWN_BUS    = 8'h00,
  parameter logic [7:0]  OWN_DEVFN  = 8'h18,
  parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID  = 16'h3C4D,
  parameter logic [7:0]  REVISION   = 8'h05,
  parameter logic [23:0] CLASS_CODE = 24'h020000,
  parameter logic [7:0]  HDR_TYPE   = 8'h00,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter logic [34:0] BAR_LOG2   = {5'd16, 5'd0, 5'd0, 5'd0, 5'd0, 5'd5, 5'd12},
  parameter logic [6:0]  BAR_IO     = 7'b0000010
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic         req_we,
  input  logic [1:0]   req_size,
  input  logic [23:0]  req_addr,
  input  logic [31:0]  req_wdata,
  output logic         rsp_valid,
  output logic [31:0]  rsp_data,
  output logic [15:0]  cmd_reg,
  output logic [223:0] bar_flat,
  output logic [7:0]   sec_bus,
  output logic         remap
);

  localparam int         NBAR      = 7;
  localparam int         ROM_IDX   = NBAR - 1;
  localparam int         NBYTES    = 256;
  localparam bit         IS_BRIDGE = HDR_TYPE[6:0] != 7'd0;
  localparam logic [7:0] ROM_OFF   = IS_BRIDGE ? 8'h38 : 8'h30;

  logic [7:0] cfg [NBYTES];

  function automatic logic [31:0] size_mask(input int k);
    return (32'd1 << BAR_LOG2[5*k +: 5]) - 32'd1;
  endfunction

  function automatic logic read_only(input logic [7:0] a);
    logic base;
    base = (a <= 8'h03) || (a >= 8'h06 && a <= 8'h0B) || (a == 8'h0E) ||
           (a >= 8'h2C && a <= 8'h2F) || (a == 8'h3D);
    if (IS_BRIDGE) return base || (a >= 8'h38 && a <= 8'h3B);
    return base || (a >= 8'h10 && a <= 8'h27) || (a >= 8'h30 && a <= 8'h33);
  endfunction

  logic [7:0]  off;
  logic        hit, acc_wr;
  logic [2:0]  wlen, rlen;
  logic [31:0] rd_hit, rd_miss, bar_val;
  logic [2:0]  bar_idx;
  logic        bar_region, bar_go, cmd_touch;
  logic [3:0]  wen;
  logic [7:0]  waddr [4];
  logic [7:0]  wbyte [4];

  assign off       = req_addr[7:0];
  assign hit       = (req_addr[23:16] == OWN_BUS) && (req_addr[15:8] == OWN_DEVFN);
  assign acc_wr    = req_valid && req_we && hit;
  assign req_ready = 1'b1;
  assign wlen      = (req_size == 2'd0) ? 3'd1 : (req_size == 2'd1) ? 3'd2 : 3'd4;
  assign rlen      = (wlen == 3'd4 && off <= 8'hFC) ? 3'd4 :
                     (wlen >= 3'd2 && off <= 8'hFE) ? 3'd2 : 3'd1;
  assign rd_miss   = (req_size == 2'd0) ? 32'h0000_00FF :
                     (req_size == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign cmd_touch = ({1'b0, off} < 9'd6) && (({1'b0, off} + {6'd0, wlen}) > 9'd4);

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      rd_hit[8*i +: 8] = (3'(i) < rlen) ? cfg[off + 8'(i)] : 8'h00;
    end
  end

  always_comb begin
    bar_region = (off == ROM_OFF) || (off >= 8'h10 && off <= 8'h27);
    bar_idx    = (off == ROM_OFF) ? 3'(ROM_IDX) : 3'((off - 8'h10) >> 2);
    bar_go     = req_size[1] && (off[1:0] == 2'b00) && bar_region &&
                 (BAR_LOG2[5*int'(bar_idx) +: 5] != 5'd0);
    if (int'(bar_idx) == ROM_IDX)
      bar_val = req_wdata & (~size_mask(int'(bar_idx)) | 32'h1);
    else
      bar_val = (req_wdata & ~size_mask(int'(bar_idx))) | {31'd0, BAR_IO[bar_idx]};
  end

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      waddr[i] = off + 8'(i);
      wen[i]   = (3'(i) < wlen) && (({1'b0, off} + 9'(i)) <= 9'd255) && !read_only(off + 8'(i));
      wbyte[i] = req_wdata[8*i +: 8] & ((off + 8'(i) == 8'h05) ? 8'h07 : 8'hFF);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NBYTES; a++) cfg[a] <= 8'h00;
      cfg[8'h00] <= VENDOR_ID[7:0];
      cfg[8'h01] <= VENDOR_ID[15:8];
      cfg[8'h02] <= DEVICE_ID[7:0];
      cfg[8'h03] <= DEVICE_ID[15:8];
      cfg[8'h08] <= REVISION;
      cfg[8'h09] <= CLASS_CODE[7:0];
      cfg[8'h0A] <= CLASS_CODE[15:8];
      cfg[8'h0B] <= CLASS_CODE[23:16];
      cfg[8'h0E] <= HDR_TYPE;
      cfg[8'h3D] <= INT_PIN;
      for (int k = 0; k < ROM_IDX; k++)
        if (BAR_LOG2[5*k +: 5] != 5'd0) cfg[16 + 4*k] <= {7'd0, BAR_IO[k]};
    end else if (acc_wr) begin
      if (bar_go) begin
        for (int i = 0; i < 4; i++) cfg[off + 8'(i)] <= bar_val[8*i +: 8];
      end else begin
        for (int i = 0; i < 4; i++) if (wen[i]) cfg[waddr[i]] <= wbyte[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 32'h0;
      remap     <= 1'b0;
    end else begin
      rsp_valid <= req_valid && !req_we;
      if (req_valid && !req_we) rsp_data <= hit ? rd_hit : rd_miss;
      remap     <= acc_wr && (bar_go || cmd_touch);
    end
  end

  assign cmd_reg = {cfg[8'h05], cfg[8'h04]};
  assign sec_bus = IS_BRIDGE ? cfg[8'h19] : 8'h00;

  for (genvar k = 0; k < NBAR; k++) begin : g_bar
    localparam int         BO = (k == ROM_IDX) ? int'(ROM_OFF) : 16 + 4*k;
    localparam logic [31:0] MK = (32'd1 << BAR_LOG2[5*k +: 5]) - 32'd1;
    assign bar_flat[32*k +: 32] = {cfg[BO+3], cfg[BO+2], cfg[BO+1], cfg[BO]};
    if (!IS_BRIDGE && BAR_LOG2[5*k +: 5] != 5'd0) begin : g_chk
      if (k == ROM_IDX) begin : g_rom
        assert_rom_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
          (bar_flat[32*k +: 32] & MK & 32'hFFFF_FFFE) == 32'h0);
      end else begin : g_reg
        assert_bar_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
          (bar_flat[32*k +: 32] & MK) == {31'd0, BAR_IO[k]});
      end
    end
  end

  assert_read_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rsp_valid);
  assert_write_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we) |=> !rsp_valid);
  assert_miss_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && !hit) |=> (rsp_data[7:0] == 8'hFF));
  assert_cmd_resv_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reg[15:11] == 5'd0);
  assert_remap_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    remap |-> $past(req_valid && req_we));
  assert_id_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(cfg[8'h00]) && $stable(cfg[8'h0E])));

endmodule

// File: tb/tb_cfgspace_rf.sv
`timescale 1ns/1ps
module tb_cfgspace_rf;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  localparam logic [7:0] DF_A = 8'h18;
  localparam logic [7:0] DF_B = 8'h20;

  logic         rst_n, req_valid, req_we;
  logic [1:0]   req_size;
  logic [23:0]  req_addr;
  logic [31:0]  req_wdata;
  logic         rdy [2];
  logic         rv [2];
  logic [31:0]  rd [2];
  logic [15:0]  cmd [2];
  logic [223:0] bar [2];
  logic [7:0]   sec [2];
  logic         rmp [2];

  cfgspace_rf #(.OWN_BUS(8'h00), .OWN_DEVFN(DF_A)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[0]), .req_we(req_we),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv[0]),
    .rsp_data(rd[0]), .cmd_reg(cmd[0]), .bar_flat(bar[0]), .sec_bus(sec[0]), .remap(rmp[0]));

  cfgspace_rf #(.OWN_BUS(8'h00), .OWN_DEVFN(DF_B), .VENDOR_ID(16'h5566), .DEVICE_ID(16'h7788),
    .REVISION(8'h02), .CLASS_CODE(24'h060400), .HDR_TYPE(8'h01), .INT_PIN(8'h00),
    .BAR_LOG2({5'd11, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd8}), .BAR_IO(7'b0)) dut_br (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[1]), .req_we(req_we),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv[1]),
    .rsp_data(rd[1]), .cmd_reg(cmd[1]), .bar_flat(bar[1]), .sec_bus(sec[1]), .remap(rmp[1]));

  int nchk = 0, nerr = 0;
  logic [7:0] m [2][256];
  int lg [2][7];
  bit io [2][7];
  logic [31:0] lf = 32'h1357_9BDF;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit ro(int br, int a);
    bit b;
    b = (a <= 3) || (a >= 6 && a <= 11) || a == 14 || (a >= 44 && a <= 47) || a == 61;
    if (br != 0) return b || (a >= 56 && a <= 59);
    return b || (a >= 16 && a <= 39) || (a >= 48 && a <= 51);
  endfunction

  task automatic model_reset();
    for (int u = 0; u < 2; u++) for (int a = 0; a < 256; a++) m[u][a] = 8'h00;
    m[0][0] = 8'h2B; m[0][1] = 8'h1A; m[0][2] = 8'h4D; m[0][3] = 8'h3C;
    m[0][8] = 8'h05; m[0][9] = 8'h00; m[0][10] = 8'h00; m[0][11] = 8'h02;
    m[0][14] = 8'h00; m[0][61] = 8'h01; m[0][20] = 8'h01;
    m[1][0] = 8'h66; m[1][1] = 8'h55; m[1][2] = 8'h88; m[1][3] = 8'h77;
    m[1][8] = 8'h02; m[1][9] = 8'h00; m[1][10] = 8'h04; m[1][11] = 8'h06;
    m[1][14] = 8'h01; m[1][61] = 8'h00;
  endtask

  function automatic int wl(int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_read(int br, int off, int sz);
    int n;
    logic [31:0] v;
    n = (wl(sz) == 4 && off <= 252) ? 4 : (wl(sz) >= 2 && off <= 254) ? 2 : 1;
    v = 32'h0;
    for (int i = 0; i < n; i++) v[8*i +: 8] = m[br][off+i];
    return v;
  endfunction

  task automatic model_write(input int br, input int off, input int sz, input logic [31:0] d,
                             output bit rm);
    int idx, rom;
    logic [31:0] mk, v;
    logic [7:0] b;
    rom = (br != 0) ? 56 : 48;
    idx = -1;
    if (off == rom) idx = 6;
    else if (off >= 16 && off <= 39) idx = (off - 16) / 4;
    if (sz >= 2 && off % 4 == 0 && idx >= 0 && lg[br][idx] != 0) begin
      mk = (32'd1 << lg[br][idx]) - 32'd1;
      if (idx == 6) v = d & (~mk | 32'h1);
      else v = (d & ~mk) | {31'd0, io[br][idx]};
      for (int i = 0; i < 4; i++) m[br][off+i] = v[8*i +: 8];
      rm = 1'b1;
    end else begin
      for (int i = 0; i < wl(sz); i++) begin
        if (off + i <= 255 && !ro(br, off + i)) begin
          b = d[8*i +: 8];
          if (off + i == 5) b = b & 8'h07;
          m[br][off+i] = b;
        end
      end
      rm = (off < 6) && (off + wl(sz) > 4);
    end
  endtask

  task automatic op(input bit we, input logic [7:0] bus, input logic [7:0] dfn, input int off,
                    input int sz, input logic [31:0] d, input string tag);
    bit h, rm;
    logic [31:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_size = 2'(sz);
    req_addr = {bus, dfn, 8'(off)}; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    for (int u = 0; u < 2; u++) begin
      h = (bus == 8'h00) && (dfn == ((u != 0) ? DF_B : DF_A));
      chk(rdy[u] == 1'b1, "R3 ready", {31'd0, rdy[u]}, 32'h1);
      if (we) begin
        rm = 1'b0;
        if (h) model_write(u, off, sz, d, rm);
        chk(rmp[u] == rm, "R12 remap", {31'd0, rmp[u]}, {31'd0, rm});
        chk(rv[u] == 1'b0, "R3 no rsp on write", {31'd0, rv[u]}, 32'h0);
      end else begin
        chk(rv[u] == 1'b1, "R3 rsp after read", {31'd0, rv[u]}, 32'h1);
        if (h) begin
          e = exp_read(u, off, sz);
          chk(rd[u] == e, tag, rd[u], e);
        end else begin
          e = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
          chk(rd[u] == e, "R2 absent ones", rd[u], e);
        end
      end
    end
  endtask

  task automatic sweep(input string tag);
    for (int u = 0; u < 2; u++)
      for (int sz = 0; sz < 3; sz++)
        for (int a = 0; a < 256; a++) op(1'b0, 8'h00, (u != 0) ? DF_B : DF_A, a, sz, 32'h0, tag);
  endtask

  task automatic outs(input string tag);
    logic [31:0] e;
    int bo;
    for (int u = 0; u < 2; u++) begin
      for (int k = 0; k < 7; k++) begin
        bo = (k == 6) ? ((u != 0) ? 56 : 48) : 16 + 4*k;
        e = {m[u][bo+3], m[u][bo+2], m[u][bo+1], m[u][bo]};
        chk(bar[u][32*k +: 32] == e, {tag, " R8 bar out"}, bar[u][32*k +: 32], e);
      end
      chk(cmd[u] == {m[u][5], m[u][4]}, {tag, " R11 cmd out"}, {16'd0, cmd[u]}, {16'd0, m[u][5], m[u][4]});
    end
    chk(sec[1] == m[1][25], {tag, " R13 bridge sec_bus"}, {24'd0, sec[1]}, {24'd0, m[1][25]});
    chk(sec[0] == 8'h00, {tag, " R13 normal sec_bus"}, {24'd0, sec[0]}, 32'h0);
  endtask

  function automatic logic [31:0] rnd();
    lf = lf ^ (lf << 13);
    lf = lf ^ (lf >> 17);
    lf = lf ^ (lf << 5);
    return lf;
  endfunction

  initial begin
    repeat (120000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    lg[0] = '{12, 5, 0, 0, 0, 0, 16};
    io[0] = '{0, 1, 0, 0, 0, 0, 0};
    lg[1] = '{8, 0, 0, 0, 0, 0, 11};
    io[1] = '{0, 0, 0, 0, 0, 0, 0};
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_size = 2'd0;
    req_addr = 24'h0; req_wdata = 32'h0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(rv[0] == 1'b0 && rv[1] == 1'b0, "R3 reset rsp_valid", {31'd0, rv[0]}, 32'h0);
    chk(bar[0][63:32] == 32'h1, "R5 reset io bar type", bar[0][63:32], 32'h1);
    outs("R5 reset");
    for (int u = 0; u < 2; u++)
      for (int a = 0; a < 256; a++) op(1'b0, 8'h00, (u != 0) ? DF_B : DF_A, a, 0, 32'h0, "R5 reset bytes");

    for (int a = 0; a < 256; a++) begin
      op(1'b1, 8'h00, DF_A, a, 0, 32'(8'(a) ^ 8'h5A), "R6");
      op(1'b1, 8'h00, DF_B, a, 0, 32'(8'(a) ^ 8'hC3), "R7");
    end
    sweep("R6 R7 R4 byte tables");
    outs("R6 R7");

    op(1'b1, 8'h00, DF_A, 16, 2, 32'hFFFF_FFFF, "R8");
    chk(bar[0][31:0] == 32'hFFFF_F000, "R8 mem bar mask", bar[0][31:0], 32'hFFFF_F000);
    op(1'b1, 8'h00, DF_A, 20, 3, 32'hFFFF_FFFF, "R8");
    chk(bar[0][63:32] == 32'hFFFF_FFE1, "R8 io bar mask", bar[0][63:32], 32'hFFFF_FFE1);
    op(1'b1, 8'h00, DF_A, 24, 2, 32'hFFFF_FFFF, "R8");
    chk(bar[0][95:64] == 32'h0, "R8 unimplemented bar", bar[0][95:64], 32'h0);
    op(1'b1, 8'h00, DF_A, 16, 1, 32'h0000_1234, "R8");
    chk(bar[0][31:0] == 32'hFFFF_F000, "R8 word write ignored", bar[0][31:0], 32'hFFFF_F000);
    op(1'b1, 8'h00, DF_A, 48, 2, 32'hFFFF_FFFE, "R9");
    chk(bar[0][223:192] == 32'hFFFF_0000, "R9 rom disabled", bar[0][223:192], 32'hFFFF_0000);
    op(1'b1, 8'h00, DF_A, 48, 2, 32'h1234_5679, "R9");
    chk(bar[0][223:192] == 32'h1234_0001, "R9 rom enable kept", bar[0][223:192], 32'h1234_0001);
    op(1'b1, 8'h00, DF_B, 16, 2, 32'hFFFF_FFFF, "R8");
    chk(bar[1][31:0] == 32'hFFFF_FF00, "R8 bridge bar mask", bar[1][31:0], 32'hFFFF_FF00);
    op(1'b1, 8'h00, DF_B, 20, 2, 32'hCAFE_BABE, "R7");
    chk(bar[1][63:32] == 32'hCAFE_BABE, "R7 bridge raw bar bytes", bar[1][63:32], 32'hCAFE_BABE);
    op(1'b1, 8'h00, DF_B, 56, 2, 32'hFFFF_FFFF, "R9");
    chk(bar[1][223:192] == 32'hFFFF_F801, "R9 bridge rom", bar[1][223:192], 32'hFFFF_F801);
    op(1'b1, 8'h00, DF_A, 254, 2, 32'h1122_3344, "R10");
    op(1'b0, 8'h00, DF_A, 254, 2, 32'h0, "R10 R4 top fallback");
    chk(m[0][0] == 8'h2B, "R10 no wrap", {24'd0, m[0][0]}, 32'h2B);
    op(1'b1, 8'h00, DF_A, 253, 1, 32'h0000_A1B2, "R10");
    op(1'b0, 8'h00, DF_A, 253, 3, 32'h0, "R4 size3 fallback");
    op(1'b1, 8'h00, DF_A, 4, 1, 32'h0000_FFFF, "R11");
    chk(cmd[0] == 16'h07FF, "R11 reserved cmd bits", {16'd0, cmd[0]}, 32'h07FF);
    op(1'b1, 8'h00, DF_B, 25, 0, 32'h0000_00A5, "R13");
    chk(sec[1] == 8'hA5, "R13 secondary bus", {24'd0, sec[1]}, 32'hA5);
    op(1'b1, 8'h01, DF_A, 64, 2, 32'hDEAD_BEEF, "R1");
    op(1'b1, 8'h00, 8'h19, 64, 2, 32'hDEAD_BEEF, "R1");
    op(1'b0, 8'h00, DF_A, 64, 2, 32'h0, "R1 absent write ignored");
    for (int sz = 0; sz < 4; sz++) op(1'b0, 8'h02, 8'h00, 8, sz, 32'h0, "R2");
    outs("directed");

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      logic [7:0] bus, dfn;
      r = rnd();
      bus = (r[31:28] == 4'hF) ? 8'h01 : 8'h00;
      dfn = r[27] ? DF_B : DF_A;
      if (r[26:24] == 3'd7) dfn = 8'h00;
      op(r[23], bus, dfn, (r[22] ? int'(r[7:0]) : int'(r[5:0])), int'(r[9:8]), rnd(), "R4 R6 R7 R8 random");
    end
    sweep("R1 R6 R7 R10 final");
    outs("final");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule